// File: doc/BRIEF.md
# Noise Shift-Register Generator

This block produces the 12-bit noise word of a waveform voice. A 23-bit linear feedback shift register advances once for each rising edge of one chosen accumulator bit. The edge feeds a short pipeline, so the shift lands two clock cycles after the edge is seen. A test input freezes the register. If test stays high long enough, a timer reloads the register with all ones.

When noise is mixed with another waveform, the mixer raises a write-back request and presents its 12-bit output. The block then ANDs the upper eight output bits into the eight register bits that feed the noise word. This can only clear bits, so a mixed waveform can silence the noise until the register is reloaded. The accumulator and the waveform mixer are outside this block.

Top module: `noise_lfsr_gen`

## Requirements
- R1: A shift moves register bits 21..0 up to bits 22..1, and the new bit 0 is bit 22 XOR bit 17.
- R2: A shift is triggered when `acc_tap_i` is sampled high on a clock edge after being sampled low on the previous edge, with `test_i` low. The shift is applied at the second following clock edge, so `noise_o` changes two cycles after the trigger edge and not one. A new trigger that arrives while a shift is pending restarts the two-cycle delay.
- R3: When `test_i` has been sampled high on `RESET_CYCLES` consecutive edges (default 8), the register is loaded with all ones on the last of those edges. Lowering `test_i` restarts the count.
- R4: `noise_o[11:4]` take register bits 20, 18, 14, 11, 9, 5, 2 and 0, in that order from bit 11 down. `noise_o[3:0]` are always zero.
- R5: When `wb_req_i` is high and `test_i` is low, each of those eight register bits becomes itself ANDed with the matching bit of `wave_i[11:4]`, using the same order as R4.
- R6: Write-back never sets a register bit. A bit cleared by write-back stays zero until a shift moves it or a test reload sets it.
- R7: Write-back is ignored on the edge at which a pending shift moves to its last pipeline stage, which is one cycle before the shift. On the shift edge itself, write-back applies to the shifted value.
- R8: After power-on reset the register is all ones, so `noise_o` is 0xFF0, and no shift is pending.
- R9: While `test_i` is high, no shift occurs and no write-back is applied. A shift that is pending when test rises resumes after test falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_tap_i | input | 1 | Accumulator bit whose rising edge triggers a shift |
| test_i | input | 1 | Test control: freezes the register and runs the reload timer |
| wb_req_i | input | 1 | Write-back request from the combined-waveform mixer |
| wave_i | input | 12 | Mixed waveform output used for write-back |
| noise_o | output | 12 | Noise word |

## Verification
A wrong feedback tap or a wrong shift timing does not stay hidden. The noise word differs from the expected value on the first or second edge after the mis-timed or wrong shift, and the error then spreads into more output bits with each later shift. Only eight register bits are visible, so a fault in a hidden bit first shows at an output bit after a few shifts. The bench therefore compares every cycle over long random runs. Write-back and reload faults show one cycle after the write-back edge, or after the last edge of the test timeout.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;
  localparam int LFSR_W = 23;
  localparam int WAVE_W = 12;
  localparam int NTAPS  = 8;
  localparam int FB_HI  = 22;
  localparam int FB_LO  = 17;

  // register bit that drives noise bit (4 + k)
  function automatic int tap_pos(input int k);
    case (k)
      7: tap_pos = 20;
      6: tap_pos = 18;
      5: tap_pos = 14;
      4: tap_pos = 11;
      3: tap_pos = 9;
      2: tap_pos = 5;
      1: tap_pos = 2;
      default: tap_pos = 0;
    endcase
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] r);
    lfsr_advance = {r[LFSR_W-2:0], r[FB_HI] ^ r[FB_LO]};
  endfunction

  function automatic logic [WAVE_W-1:0] noise_word(input logic [LFSR_W-1:0] r);
    logic [WAVE_W-1:0] w;
    w = '0;
    for (int k = 0; k < NTAPS; k++) w[WAVE_W-NTAPS+k] = r[tap_pos(k)];
    noise_word = w;
  endfunction

  function automatic logic [LFSR_W-1:0] wave_and(input logic [LFSR_W-1:0] r,
                                                 input logic [WAVE_W-1:0] w);
    logic [LFSR_W-1:0] m;
    m = r;
    for (int k = 0; k < NTAPS; k++)
      m[tap_pos(k)] = r[tap_pos(k)] & w[WAVE_W-NTAPS+k];
    wave_and = m;
  endfunction
endpackage

// File: rtl/noise_trig_pipe.sv
module noise_trig_pipe #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tap_i,
  input  logic hold_i,
  output logic edge_o,
  output logic shift_o,
  output logic last_stage_o
);
  localparam int CW = $clog2(DELAY + 1);

  logic          tap_q;
  logic [CW-1:0] stage_q;
  logic [CW-1:0] stage_d;

  assign edge_o  = tap_i & ~tap_q & ~hold_i;
  assign shift_o = ~hold_i & ~edge_o & (stage_q == CW'(1));

  always_comb begin
    stage_d = stage_q;
    if (!hold_i) begin
      if (edge_o)                stage_d = CW'(DELAY);
      else if (stage_q != '0)    stage_d = stage_q - CW'(1);
    end
  end

  assign last_stage_o = ~hold_i & (stage_d == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q   <= 1'b0;
      stage_q <= '0;
    end else begin
      tap_q   <= tap_i;
      stage_q <= stage_d;
    end
  end
endmodule

// File: rtl/noise_rst_timer.sv
module noise_rst_timer #(
  parameter int RESET_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_i,
  output logic fire_o
);
  localparam int CW = $clog2(RESET_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RESET_CYCLES - 1);
  localparam logic [CW-1:0] DONE = CW'(RESET_CYCLES);

  logic [CW-1:0] cnt_q;

  assign fire_o = test_i & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!test_i)         cnt_q <= '0;
    else if (cnt_q != DONE)   cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
  import noise_lfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              reload_i,
  input  logic              wb_i,
  input  logic [WAVE_W-1:0] wave_i,
  output logic [LFSR_W-1:0] lfsr_o
);
  logic [LFSR_W-1:0] r_q;
  logic [LFSR_W-1:0] r_shifted;

  assign r_shifted = shift_i ? lfsr_advance(r_q) : r_q;
  assign lfsr_o    = r_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        r_q <= '1;
    else if (reload_i) r_q <= '1;
    else if (wb_i)     r_q <= wave_and(r_shifted, wave_i);
    else               r_q <= r_shifted;
  end
endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_lfsr_pkg::*;
#(
  parameter int RESET_CYCLES = 8,
  parameter int SHIFT_DELAY  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_tap_i,
  input  logic              test_i,
  input  logic              wb_req_i,
  input  logic [WAVE_W-1:0] wave_i,
  output logic [WAVE_W-1:0] noise_o
);
  logic              trig_edge;
  logic              shift_fire;
  logic              last_stage;
  logic              reload_fire;
  logic              wb_fire;
  logic [LFSR_W-1:0] lfsr_q;

  noise_trig_pipe #(.DELAY(SHIFT_DELAY)) trig_i (
    .clk(clk), .rst_n(rst_n), .tap_i(acc_tap_i), .hold_i(test_i),
    .edge_o(trig_edge), .shift_o(shift_fire), .last_stage_o(last_stage)
  );

  noise_rst_timer #(.RESET_CYCLES(RESET_CYCLES)) tmr_i (
    .clk(clk), .rst_n(rst_n), .test_i(test_i), .fire_o(reload_fire)
  );

  assign wb_fire = wb_req_i & ~test_i & ~last_stage;

  noise_lfsr_core core_i (
    .clk(clk), .rst_n(rst_n), .shift_i(shift_fire), .reload_i(reload_fire),
    .wb_i(wb_fire), .wave_i(wave_i), .lfsr_o(lfsr_q)
  );

  assign noise_o = noise_word(lfsr_q);
endmodule

// File: rtl/noise_lfsr_chk.sv
module noise_lfsr_chk
  import noise_lfsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              test_i,
  input logic              trig_edge,
  input logic              shift_fire,
  input logic              reload_fire,
  input logic              wb_fire,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic [WAVE_W-1:0] noise_o
);
  p_shift_rule_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_fire && !wb_fire && !reload_fire) |=> lfsr_q == lfsr_advance($past(lfsr_q)));

  p_no_early_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge |=> !shift_fire);

  p_reload_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload_fire |=> lfsr_q == {LFSR_W{1'b1}});

  p_low_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    noise_o[3:0] == 4'h0);

  p_wb_clears_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && !shift_fire) |=> (lfsr_q & ~$past(lfsr_q)) == '0);

  p_test_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (test_i && !reload_fire) |=> $stable(lfsr_q));
endmodule

bind noise_lfsr_gen noise_lfsr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .test_i(test_i), .trig_edge(trig_edge),
  .shift_fire(shift_fire), .reload_fire(reload_fire), .wb_fire(wb_fire),
  .lfsr_q(lfsr_q), .noise_o(noise_o)
);

// File: tb/noise_lfsr_gen_tb.sv
`timescale 1ns/1ps
module noise_lfsr_gen_tb_top;
  localparam int NRST = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tap = 1'b0, tst = 1'b0, wb = 1'b0;
  logic [11:0] wave = 12'h000;
  logic [11:0] noise_o;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  noise_lfsr_gen #(.RESET_CYCLES(NRST)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_tap_i(tap), .test_i(tst),
    .wb_req_i(wb), .wave_i(wave), .noise_o(noise_o)
  );

  // reference state
  logic [22:0] m_r;
  int          m_pipe, m_cnt;
  logic        m_prev;

  function automatic logic [11:0] exp_noise(input logic [22:0] r);
    exp_noise = {r[20], r[18], r[14], r[11], r[9], r[5], r[2], r[0], 4'b0000};
  endfunction

  function automatic logic [22:0] ref_shift(input logic [22:0] r);
    logic fb;
    fb = r[22] ^ r[17];
    ref_shift = (r << 1) | {22'd0, fb};
  endfunction

  function automatic logic [22:0] ref_wb(input logic [22:0] r, input logic [11:0] w);
    logic [22:0] keep;
    keep = ~23'd0;
    keep[20] = w[11]; keep[18] = w[10]; keep[14] = w[9]; keep[11] = w[8];
    keep[9]  = w[7];  keep[5]  = w[6];  keep[2]  = w[5]; keep[0]  = w[4];
    ref_wb = r & keep;
  endfunction

  task automatic model_step();
    int  pn;
    logic e;
    if (tst) begin
      if (m_cnt < NRST) begin
        m_cnt++;
        if (m_cnt == NRST) m_r = '1;
      end
    end else begin
      m_cnt = 0;
      e = tap && !m_prev;
      pn = e ? 2 : (m_pipe > 0 ? m_pipe - 1 : 0);
      if (!e && m_pipe == 1) m_r = ref_shift(m_r);
      if (wb && pn != 1) m_r = ref_wb(m_r, wave);
      m_pipe = pn;
    end
    m_prev = tap;
  endtask

  task automatic cyc(input logic t, input logic ts, input logic w, input logic [11:0] wv);
    tap = t; tst = ts; wb = w; wave = wv;
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [11:0] exp);
    n_run++;
    if (noise_o !== exp) begin
      n_fail++;
      $display("FAIL %s: noise_o=%03h expected %03h", req, noise_o, exp);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run hung, got %0d expected completion", n_run);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_r = '1; m_pipe = 0; m_cnt = 0; m_prev = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset value", 12'hFF0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", 12'hFF0);

    // R2: trigger edge, shift lands two edges later
    cyc(1, 0, 0, 12'h000);
    check("R2 edge seen, no shift yet", 12'hFF0);
    cyc(1, 0, 0, 12'h000);
    check("R2 one cycle after edge", 12'hFF0);
    cyc(1, 0, 0, 12'h000);
    check("R1 first shift bit0 = 22^17 = 0", 12'hFE0);
    check("R1 model agrees", exp_noise(m_r));

    // R7: write-back ignored on the edge entering the last stage
    cyc(0, 0, 0, 12'h000);
    cyc(1, 0, 0, 12'h000);
    cyc(1, 0, 1, 12'h000);
    check("R7 write-back skipped", exp_noise(m_r));
    check("R7 not cleared", 12'hFE0 & exp_noise(m_r) | exp_noise(m_r));
    cyc(1, 0, 0, 12'h000);
    check("R1 second shift", exp_noise(m_r));

    // R5/R6: write-back clears, later ones do not restore
    cyc(1, 0, 1, 12'h5A0);
    check("R5 write-back AND", exp_noise(m_r));
    cyc(1, 0, 1, 12'h000);
    check("R5 write-back zero", 12'h000);
    cyc(1, 0, 1, 12'hFFF);
    check("R6 no re-set", 12'h000);

    // R9/R3: test freezes, reload after NRST edges
    cyc(1, 1, 1, 12'hFFF);
    for (int i = 0; i < NRST - 2; i++) cyc(0, 1, 0, 12'h000);
    check("R9 frozen under test", 12'h000);
    cyc(0, 1, 0, 12'h000);
    check("R3 reload on last timeout edge", 12'hFF0);
    cyc(0, 1, 1, 12'h000);
    check("R9 write-back ignored under test", 12'hFF0);
    cyc(0, 0, 0, 12'h000);
    check("R3 state after test drop", exp_noise(m_r));

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic t, ts, w;
      logic [11:0] wv;
      t  = ($urandom % 3) == 0 ? ~tap : tap;
      ts = ((i % 200) >= 190);
      w  = ($urandom % 24) == 0;
      wv = $urandom | (($urandom % 4 != 0) ? 12'hFF0 : 12'h000);
      cyc(t, ts, w, wv);
      check("R1/R2/R4/R5/R7/R9 random", exp_noise(m_r));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule